// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A register-mapped event monitor for profiling. It holds one cycle counter and a parameterised set of general event counters (four by default). Each general counter is told which line of a 256-line event bus it watches by an 8-bit event number. Once enabled, it adds one for every clock cycle in which that line is high.

Software gets at the unit through a flat register bus with a 4-bit word address, a write strobe and a combinational read port. A global run bit gates all counting. Per-counter enables are changed through separate set and clear registers, and interrupt enables through a set register. Overflow flags are cleared by writing ones. The general counters are reached indirectly: software writes an index into a select register, then accesses the event-number and count registers for that counter.

Counters are 32 bits wide. To sample every N events, software preloads the counter with minus N. The counter then wraps after exactly N events and raises its overflow flag. The single level-sensitive interrupt output is high while any flag is set whose interrupt is enabled.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset every readable register (addresses 0 to 8) reads zero and `irq` is low.
- R2: Writing a 1 to a bit at address 1 enables that counter, and writing a 1 to a bit at address 2 disables it. Bit i (0..3) is event counter i, bit 31 is the cycle counter, and bits written as 0 have no effect. Both addresses read back the enable mask. Bits 4..30 of the enable, interrupt-enable (address 3) and flag (address 4) registers read zero.
- R3: Event counter i adds one on each clock edge at which the run bit (address 0, bit 0) is 1, its enable is 1, and line `events[evsel_i]` is high. Otherwise it holds its value.
- R4: Address 5 holds a 2-bit counter index. Addresses 6 (8-bit event number) and 7 (32-bit count) read and write only the counter that index selects.
- R5: A counter that increments from 0xFFFFFFFF wraps to 0 and sets its flag bit at address 4.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R7: `irq` is high exactly while some flag bit is set whose interrupt enable is set. Interrupt enables are set by writing 1 to a bit at address 3, with the same bit layout as R2.
- R8: Writing address 0 with bit 1 set zeroes all event counters. Writing it with bit 2 set zeroes the cycle counter and its prescaler. Neither bit is stored, and both read as 0.
- R9: The cycle counter (address 8, readable and writable) adds one on every clock edge at which the run bit and its enable are set. When address 0 bit 3 is set, it adds one only on every 64th such edge.
- R10: A bus write to a count register and an increment of that counter in the same cycle leave the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| events | input | 256 | Event lines, one per event number |
| irq | output | 1 | Level interrupt, flags AND interrupt enables |

## Verification
The bench counts the exact number of edges an event line is held high, to expose an off-by-one in the gating. It preloads counters just below the wrap to catch a flag that fires one event early or late, or a counter that saturates instead of wrapping. A count write collides with a live increment: a design that lets the increment win would read 0x101 plus the later events instead of 0x102. The divide-by-64 mode runs for 128 enabled cycles and must read exactly 2. Writes of zero to the clear registers, a flag that is set but not interrupt-enabled, and the not-stored reset bits are each checked at the read port, where a sloppy decode would show up as changed bits.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int CNT_W_DEF    = 32;
    localparam int NUM_EV_DEF   = 4;
    localparam int EVSEL_W_DEF  = 8;
    localparam int DIV_LOG2_DEF = 6;
    localparam int ADDR_W       = 4;

    // control register bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_PRST = 1;
    localparam int CTRL_CRST = 2;
    localparam int CTRL_DIV  = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 4'd0,
        REG_ENSET  = 4'd1,
        REG_ENCLR  = 4'd2,
        REG_IRQSET = 4'd3,
        REG_OVF    = 4'd4,
        REG_SEL    = 4'd5,
        REG_EVSEL  = 4'd6,
        REG_COUNT  = 4'd7,
        REG_CYCLE  = 4'd8
    } reg_addr_e;

    // write request into one counter's count register
    typedef struct packed {
        logic                 we;
        logic [CNT_W_DEF-1:0] data;
    } cnt_wr_t;

    function automatic logic addr_is(logic [ADDR_W-1:0] a, reg_addr_e r);
        return a == r;
    endfunction

endpackage

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr
    import pmu_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int EVSEL_W = EVSEL_W_DEF,
    localparam int LINES  = 1 << EVSEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               zero_req,
    input  logic               run,
    input  logic [LINES-1:0]   events,
    input  logic               evsel_we,
    input  logic [EVSEL_W-1:0] evsel_wdata,
    input  cnt_wr_t            cnt_wr,
    output logic [EVSEL_W-1:0] evsel_q,
    output logic [CNT_W-1:0]   count_q,
    output logic               wrap
);

    logic hit;
    logic inc;

    assign hit  = run && events[evsel_q];
    assign inc  = hit && !zero_req && !cnt_wr.we;
    assign wrap = inc && (&count_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            evsel_q <= '0;
        end else if (evsel_we) begin
            evsel_q <= evsel_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || zero_req) begin
            count_q <= '0;
        end else if (cnt_wr.we) begin
            count_q <= cnt_wr.data[CNT_W-1:0];
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr
    import pmu_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int DIV_LOG2 = DIV_LOG2_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zero_req,
    input  logic             run,
    input  logic             slow,
    input  cnt_wr_t          cnt_wr,
    output logic [CNT_W-1:0] count_q,
    output logic             inc,
    output logic             wrap
);

    logic [DIV_LOG2-1:0] pre_q;
    logic                tick;

    assign tick = run && (!slow || (&pre_q));
    assign inc  = tick && !zero_req && !cnt_wr.we;
    assign wrap = inc && (&count_q);

    always_ff @(posedge clk) begin
        if (rst || zero_req) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || zero_req) begin
            count_q <= '0;
        end else if (cnt_wr.we) begin
            count_q <= cnt_wr.data[CNT_W-1:0];
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int NUM_EV   = NUM_EV_DEF,
    parameter int EVSEL_W  = EVSEL_W_DEF,
    parameter int DIV_LOG2 = DIV_LOG2_DEF,
    localparam int SEL_W   = (NUM_EV > 1) ? $clog2(NUM_EV) : 1,
    localparam int LINES   = 1 << EVSEL_W,
    localparam int CYC_BIT = CNT_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [LINES-1:0]  events,
    output logic              irq
);

    logic              run_q, slow_q;
    logic [NUM_EV-1:0] en_ev_q, ie_ev_q, ovf_ev_q;
    logic              en_cyc_q, ie_cyc_q, ovf_cyc_q;
    logic [SEL_W-1:0]  sel_q;

    logic wr_ctrl, wr_enset, wr_enclr, wr_irqset, wr_ovf;
    logic wr_sel, wr_evsel, wr_count, wr_cycle;
    logic zero_ev, zero_cyc;

    logic [NUM_EV-1:0][CNT_W-1:0]   ev_cnt;
    logic [NUM_EV-1:0][EVSEL_W-1:0] ev_sel;
    logic [NUM_EV-1:0]              ev_wrap;
    logic [CNT_W-1:0]               cyc_cnt;
    logic                           cyc_inc, cyc_wrap;

    logic [CNT_W-1:0] en_view, ie_view, flag_view;

    assign wr_ctrl   = bus_wr && addr_is(bus_addr, REG_CTRL);
    assign wr_enset  = bus_wr && addr_is(bus_addr, REG_ENSET);
    assign wr_enclr  = bus_wr && addr_is(bus_addr, REG_ENCLR);
    assign wr_irqset = bus_wr && addr_is(bus_addr, REG_IRQSET);
    assign wr_ovf    = bus_wr && addr_is(bus_addr, REG_OVF);
    assign wr_sel    = bus_wr && addr_is(bus_addr, REG_SEL);
    assign wr_evsel  = bus_wr && addr_is(bus_addr, REG_EVSEL);
    assign wr_count  = bus_wr && addr_is(bus_addr, REG_COUNT);
    assign wr_cycle  = bus_wr && addr_is(bus_addr, REG_CYCLE);

    assign zero_ev  = wr_ctrl && bus_wdata[CTRL_PRST];
    assign zero_cyc = wr_ctrl && bus_wdata[CTRL_CRST];

    // global control and select
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            slow_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= bus_wdata[CTRL_RUN];
                slow_q <= bus_wdata[CTRL_DIV];
            end
            if (wr_sel) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
        end
    end

    // enables, interrupt enables, overflow flags
    always_ff @(posedge clk) begin
        if (rst) begin
            en_ev_q   <= '0;
            en_cyc_q  <= 1'b0;
            ie_ev_q   <= '0;
            ie_cyc_q  <= 1'b0;
            ovf_ev_q  <= '0;
            ovf_cyc_q <= 1'b0;
        end else begin
            if (wr_enset) begin
                en_ev_q  <= en_ev_q | bus_wdata[NUM_EV-1:0];
                en_cyc_q <= en_cyc_q | bus_wdata[CYC_BIT];
            end else if (wr_enclr) begin
                en_ev_q  <= en_ev_q & ~bus_wdata[NUM_EV-1:0];
                en_cyc_q <= en_cyc_q & ~bus_wdata[CYC_BIT];
            end
            if (wr_irqset) begin
                ie_ev_q  <= ie_ev_q | bus_wdata[NUM_EV-1:0];
                ie_cyc_q <= ie_cyc_q | bus_wdata[CYC_BIT];
            end
            ovf_ev_q  <= (ovf_ev_q & ~({NUM_EV{wr_ovf}} & bus_wdata[NUM_EV-1:0]))
                         | ev_wrap;
            ovf_cyc_q <= (ovf_cyc_q & ~(wr_ovf && bus_wdata[CYC_BIT])) | cyc_wrap;
        end
    end

    // event counters
    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        cnt_wr_t cw;
        assign cw.we   = wr_count && (sel_q == SEL_W'(i));
        assign cw.data = CNT_W_DEF'(bus_wdata);

        pmu_event_ctr #(
            .CNT_W   (CNT_W),
            .EVSEL_W (EVSEL_W)
        ) u_ctr (
            .clk         (clk),
            .rst         (rst),
            .zero_req    (zero_ev),
            .run         (run_q && en_ev_q[i]),
            .events      (events),
            .evsel_we    (wr_evsel && (sel_q == SEL_W'(i))),
            .evsel_wdata (bus_wdata[EVSEL_W-1:0]),
            .cnt_wr      (cw),
            .evsel_q     (ev_sel[i]),
            .count_q     (ev_cnt[i]),
            .wrap        (ev_wrap[i])
        );
    end

    // cycle counter
    cnt_wr_t cyc_wr;
    assign cyc_wr.we   = wr_cycle;
    assign cyc_wr.data = CNT_W_DEF'(bus_wdata);

    pmu_cycle_ctr #(
        .CNT_W    (CNT_W),
        .DIV_LOG2 (DIV_LOG2)
    ) u_cyc (
        .clk      (clk),
        .rst      (rst),
        .zero_req (zero_cyc),
        .run      (run_q && en_cyc_q),
        .slow     (slow_q),
        .cnt_wr   (cyc_wr),
        .count_q  (cyc_cnt),
        .inc      (cyc_inc),
        .wrap     (cyc_wrap)
    );

    // register-layout views
    always_comb begin
        en_view   = '0;
        ie_view   = '0;
        flag_view = '0;
        en_view[NUM_EV-1:0]   = en_ev_q;
        ie_view[NUM_EV-1:0]   = ie_ev_q;
        flag_view[NUM_EV-1:0] = ovf_ev_q;
        en_view[CYC_BIT]      = en_cyc_q;
        ie_view[CYC_BIT]      = ie_cyc_q;
        flag_view[CYC_BIT]    = ovf_cyc_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTRL_RUN] = run_q;
                bus_rdata[CTRL_DIV] = slow_q;
            end
            REG_ENSET, REG_ENCLR: bus_rdata = en_view;
            REG_IRQSET:           bus_rdata = ie_view;
            REG_OVF:              bus_rdata = flag_view;
            REG_SEL:              bus_rdata[SEL_W-1:0] = sel_q;
            REG_EVSEL:            bus_rdata[EVSEL_W-1:0] = ev_sel[sel_q];
            REG_COUNT:            bus_rdata = ev_cnt[sel_q];
            REG_CYCLE:            bus_rdata = cyc_cnt;
            default:              bus_rdata = '0;
        endcase
    end

    assign irq = |(flag_view & ie_view);

endmodule

// File: rtl/pmu_counter_unit_chk.sv
module pmu_counter_unit_chk
    import pmu_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int NUM_EV = NUM_EV_DEF,
    parameter int SEL_W  = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_wr,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [CNT_W-1:0]               bus_wdata,
    input logic [CNT_W-1:0]               bus_rdata,
    input logic                           irq,
    input logic                           run_q,
    input logic [SEL_W-1:0]               sel_q,
    input logic [CNT_W-1:0]               flag_view,
    input logic [CNT_W-1:0]               cyc_cnt,
    input logic                           cyc_inc,
    input logic [NUM_EV-1:0][CNT_W-1:0]   ev_cnt
);

    logic [CNT_W-1:0] clr_mask;
    assign clr_mask = (bus_wr && bus_addr == REG_OVF) ? bus_wdata : '0;

    // R2: reserved bits of the enable view read zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_ENSET) |-> (bus_rdata[CNT_W-2:NUM_EV] == '0));

    // R5: cycle counter wrap raises its flag
    a_r5_cycle_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        (cyc_inc && (&cyc_cnt)) |=> flag_view[CNT_W-1]);

    // R6: a flag only drops when a one was written to it
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flag_view) & ~$past(clr_mask)) & ~flag_view) == '0));

    // R7: no interrupt without a flag
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (flag_view == '0) |-> !irq);

    // R8: reset bits are not stored
    a_r8_ctrl_pulse_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_CTRL) |-> (bus_rdata[2:1] == 2'b00));

    // R9: cycle counter frozen while stopped and not written
    a_r9_cycle_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !(bus_wr && (bus_addr == REG_CYCLE || bus_addr == REG_CTRL)))
        |=> $stable(cyc_cnt));

    // R10: a count write always lands
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_COUNT) |=> (ev_cnt[$past(sel_q)] == $past(bus_wdata)));

endmodule

bind pmu_counter_unit pmu_counter_unit_chk #(
    .CNT_W  (CNT_W),
    .NUM_EV (NUM_EV),
    .SEL_W  (SEL_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .run_q     (run_q),
    .sel_q     (sel_q),
    .flag_view (flag_view),
    .cyc_cnt   (cyc_cnt),
    .cyc_inc   (cyc_inc),
    .ev_cnt    (ev_cnt)
);

// File: tb/pmu_counter_unit_tb.sv
module pmu_counter_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_wr;
    logic [3:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [255:0] events;
    logic         irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pmu_counter_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .events    (events),
        .irq       (irq)
    );

    localparam logic [3:0] A_CTRL = 0, A_ENSET = 1, A_ENCLR = 2, A_IRQSET = 3,
                           A_OVF = 4, A_SEL = 5, A_EVSEL = 6, A_COUNT = 7, A_CYC = 8;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_line(input int line, input int edges);
        @(negedge clk);
        events[line] = 1'b1;
        repeat (edges) @(negedge clk);
        events[line] = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a <= 8; a++) rd_chk("R1 reset value", 4'(a), 32'h0);
        #1 check("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_enables();
        wr(A_ENSET, 32'hFFFF_FFFF);
        rd_chk("R2 set all", A_ENSET, 32'h8000_000F);
        rd_chk("R2 clear addr reads mask", A_ENCLR, 32'h8000_000F);
        wr(A_ENCLR, 32'h8000_0005);
        rd_chk("R2 partial clear", A_ENSET, 32'h0000_000A);
        wr(A_ENCLR, 32'h0);
        rd_chk("R2 zero write no effect", A_ENSET, 32'h0000_000A);
        wr(A_ENSET, 32'h0);
        rd_chk("R2 zero set no effect", A_ENSET, 32'h0000_000A);
        wr(A_ENCLR, 32'hFFFF_FFFF);
        rd_chk("R2 clear all", A_ENSET, 32'h0);
        wr(A_IRQSET, 32'h0000_0010);
        rd_chk("R2 R7 ie reserved bit", A_IRQSET, 32'h0);
    endtask

    task automatic t_counting();
        wr(A_SEL, 1); wr(A_EVSEL, 7); wr(A_COUNT, 0);
        wr(A_SEL, 0); wr(A_EVSEL, 3); wr(A_COUNT, 0);
        wr(A_SEL, 2); wr(A_EVSEL, 7); wr(A_COUNT, 0);
        wr(A_ENSET, 32'h3);
        pulse_line(7, 4);                         // run bit off: no count
        wr(A_SEL, 1);
        rd_chk("R3 gated by run bit", A_COUNT, 0);
        wr(A_CTRL, 32'h1);
        pulse_line(7, 5);
        wr(A_CTRL, 32'h0);
        rd_chk("R3 R4 counter1 counts line 7", A_COUNT, 5);
        rd_chk("R4 evsel readback", A_EVSEL, 7);
        wr(A_SEL, 0);
        rd_chk("R4 counter0 untouched", A_COUNT, 0);
        rd_chk("R4 counter0 evsel", A_EVSEL, 3);
        wr(A_SEL, 2);
        rd_chk("R3 disabled counter holds", A_COUNT, 0);
    endtask

    task automatic t_overflow();
        wr(A_SEL, 2); wr(A_EVSEL, 5); wr(A_COUNT, 32'hFFFF_FFFD);
        wr(A_ENSET, 32'h4); wr(A_IRQSET, 32'h4);
        wr(A_CTRL, 32'h1);
        pulse_line(5, 3);
        wr(A_CTRL, 32'h0);
        rd_chk("R5 wrapped to zero", A_COUNT, 0);
        rd_chk("R5 flag bit2", A_OVF, 32'h4);
        #1 check("R7 irq raised", {31'b0, irq}, 1);
        wr(A_OVF, 32'h0);
        rd_chk("R6 zero write keeps flag", A_OVF, 32'h4);
        wr(A_OVF, 32'h4);
        rd_chk("R6 one write clears", A_OVF, 32'h0);
        #1 check("R7 irq dropped", {31'b0, irq}, 0);
        // counter 3 wraps without interrupt enable
        wr(A_SEL, 3); wr(A_EVSEL, 9); wr(A_COUNT, 32'hFFFF_FFFF);
        wr(A_ENSET, 32'h8);
        wr(A_CTRL, 32'h1);
        pulse_line(9, 1);
        wr(A_CTRL, 32'h0);
        rd_chk("R5 flag bit3", A_OVF, 32'h8);
        #1 check("R7 masked flag no irq", {31'b0, irq}, 0);
        wr(A_OVF, 32'h8);
    endtask

    task automatic t_write_wins();
        wr(A_SEL, 1);
        @(negedge clk) events[7] = 1'b1;
        wr(A_CTRL, 32'h1);
        wr(A_COUNT, 32'h100);
        wr(A_CTRL, 32'h0);
        @(negedge clk) events[7] = 1'b0;
        rd_chk("R10 write beats increment", A_COUNT, 32'h102);
    endtask

    task automatic t_resets();
        wr(A_CYC, 32'h55);
        wr(A_CTRL, 32'h2);
        rd_chk("R8 event counters zeroed", A_COUNT, 0);
        rd_chk("R8 cycle counter kept", A_CYC, 32'h55);
        rd_chk("R8 pulse bits not stored", A_CTRL, 0);
        wr(A_CTRL, 32'h4);
        rd_chk("R8 cycle counter zeroed", A_CYC, 0);
    endtask

    task automatic t_cycle();
        wr(A_ENSET, 32'h8000_0000);
        wr(A_CTRL, 32'h1);
        idle(10);
        wr(A_CTRL, 32'h0);
        rd_chk("R9 full rate count", A_CYC, 12);
        wr(A_CTRL, 32'h4);
        wr(A_CTRL, 32'h9);
        rd_chk("R9 divide bit readback", A_CTRL, 32'h9);
        idle(126);
        wr(A_CTRL, 32'h8);
        rd_chk("R9 divided count", A_CYC, 2);
        wr(A_CYC, 32'hFFFF_FFFF);
        wr(A_IRQSET, 32'h8000_0000);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h0);
        rd_chk("R5 R9 cycle wrap", A_CYC, 1);
        rd_chk("R5 cycle flag bit31", A_OVF, 32'h8000_0000);
        #1 check("R7 cycle irq", {31'b0, irq}, 1);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; events = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enables();
        t_counting();
        t_overflow();
        t_write_wins();
        t_resets();
        t_cycle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule